// File: doc/BRIEF.md
# Oscillator Qualification and Default Clock Selector

This block checks the main crystal oscillator against a free-running high-frequency low-power reference oscillator, and it decides which of the two clocks drives the system once power-on reset is released. After reset rises, the block counts rising edges of the main oscillator over a fixed number of reference cycles. It accepts the oscillator only when that count lies between a lower bound and an upper bound, both taken from a 16-bit trim word. A tighter pair of bounds narrows the window of frequencies that the check accepts.

The reference oscillator drives the system clock during reset and while the first verdict is pending. When the first verdict passes, the output clock moves to the main oscillator through a glitch-free switch. When that verdict fails, or when any later verdict fails, the block falls back to the reference oscillator and stays there until the next power-on reset. The same block keeps a clock-source disable register and the per-source valid flags for the oscillator, for the reference, and for two PLLs. Each PLL starts disabled, and its valid flag follows its synchronised lock input while the PLL is enabled.

Top module: `clk_src_supervisor`

## Requirements
- R1: While `por_n` is low, `use_osc` is 0, `src_valid` is 0x00, `src_off` is 0x42, and `sys_clk` runs at the reference rate.
- R2: The first measurement window after reset release (WIN_LEN reference cycles) is discarded. No verdict, and therefore no switch to the oscillator, occurs before the end of the second window.
- R3: A verdict passes when the oscillator edge count over WIN_LEN reference cycles satisfies trim[7:0] <= count <= trim[15:8]. `src_valid[0]` holds the result of the most recent verdict.
- R4: A passing first verdict sets `use_osc`, and `sys_clk` then runs at the oscillator rate.
- R5: A failing first verdict leaves `use_osc` at 0 until the next power-on reset, even if later verdicts pass.
- R6: A failing verdict while the oscillator is selected clears `src_valid[0]` and `use_osc`. The block never selects the oscillator again before reset, and `sys_clk` returns to the reference rate.
- R7: If the oscillator stops (a count of zero) while it is selected, `sys_clk` still moves to the reference clock.
- R8: `src_off` holds one bit per source index (0 oscillator, 1 PLL1, 4 reference, 6 PLL2). A 1 on `off_clr[i]` clears the bit and a 1 on `off_set[i]` sets it, both at the next reference edge. When both are 1 for the same bit, set wins. Only bits 1 and 6 are storable, and all other bits always read 0.
- R9: `src_valid[1]` and `src_valid[6]` equal `pll_lock[0]` and `pll_lock[1]` delayed by SYNC_STAGES reference edges, each gated off while the matching `src_off` bit is 1. `src_valid[4]` is 1 once the internal reset has been released. Bits 2, 3, 5 and 7 are 0.
- R10: The oscillator-branch enable and the reference-branch enable of the clock switch are never both on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| osc_clk | input | 1 | Main crystal oscillator clock |
| ref_clk | input | 1 | High-frequency low-power reference clock |
| trim_word | input | 16 | Window bounds: [7:0] lower, [15:8] upper, in oscillator edges per window |
| pll_lock | input | 2 | Lock indications of PLL1 (bit 0) and PLL2 (bit 1), asynchronous |
| off_clr | input | 8 | Write-one-to-clear pulses for the disable register |
| off_set | input | 8 | Write-one-to-set pulses for the disable register |
| src_off | output | 8 | Clock-source disable register |
| src_valid | output | 8 | Per-source valid flags |
| use_osc | output | 1 | 1 when the main oscillator is the selected source |
| sys_clk | output | 1 | Glitch-free selected clock |

## Verification
A set pulse and a clear pulse for the same disable bit can arrive on the same reference edge. A change of a PLL's lock input and a write to that PLL's disable bit can also coincide, and both affect the valid flag on the same edge. The bench drives these combinations on a single cycle. A behavioural model that runs every reference cycle then judges the register and valid outputs. Measurement verdicts, which cross from the oscillator domain with a cycle of uncertainty, are judged at settled points and by counting `sys_clk` edges against the expected source rate.

// File: rtl/clksup_pkg.sv
package clksup_pkg;
   localparam int NSRC     = 8;
   localparam int SRC_OSC  = 0;
   localparam int SRC_PLL1 = 1;
   localparam int SRC_REF  = 4;
   localparam int SRC_PLL2 = 6;
   localparam int NPLL     = 2;

   typedef enum logic [1:0] {
      SEL_BOOT = 2'd0,
      SEL_OSC  = 2'd1,
      SEL_FALL = 2'd2
   } sel_state_e;
endpackage

// File: rtl/clksup_freq_meter.sv
module clksup_freq_meter #(
   parameter int WIN_LEN     = 64,
   parameter int MAX_RATIO   = 8,
   parameter int BOUND_W     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               osc_clk,
   input  logic               por_n,
   input  logic               ref_clk,
   input  logic               rst_ref_n,
   input  logic [BOUND_W-1:0] lo_bound,
   input  logic [BOUND_W-1:0] hi_bound,
   output logic               verdict_vld,
   output logic               verdict_pass,
   output logic               osc_stopped
);
   localparam int CNT_W = $clog2(WIN_LEN * MAX_RATIO + 1);
   localparam int WIN_W = $clog2(WIN_LEN);

   if (CNT_W < BOUND_W) begin : g_bad_cnt
      $error("count narrower than bounds");
   end
   if (WIN_LEN < 8) begin : g_bad_win
      $error("window too short");
   end

   // oscillator domain: binary count mirrored as Gray
   logic [CNT_W-1:0] bin_q, bin_nx, gray_q;
   assign bin_nx = bin_q + 1'b1;

   always_ff @(posedge osc_clk or negedge por_n) begin
      if (!por_n) begin
         bin_q  <= '0;
         gray_q <= '0;
      end else begin
         bin_q  <= bin_nx;
         gray_q <= bin_nx ^ (bin_nx >> 1);
      end
   end

   // reference domain synchroniser
   logic [CNT_W-1:0] gs_q [SYNC_STAGES];
   always_ff @(posedge ref_clk or negedge rst_ref_n) begin
      if (!rst_ref_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) gs_q[i] <= '0;
      end else begin
         gs_q[0] <= gray_q;
         for (int i = 1; i < SYNC_STAGES; i++) gs_q[i] <= gs_q[i-1];
      end
   end

   logic [CNT_W-1:0] bin_now;
   always_comb begin
      bin_now[CNT_W-1] = gs_q[SYNC_STAGES-1][CNT_W-1];
      for (int i = CNT_W - 2; i >= 0; i--)
         bin_now[i] = bin_now[i+1] ^ gs_q[SYNC_STAGES-1][i];
   end

   logic [WIN_W-1:0] win_q;
   logic [CNT_W-1:0] snap_q, delta;
   logic             armed_q, win_last, in_range;

   assign win_last = (win_q == WIN_W'(WIN_LEN - 1));
   assign delta    = bin_now - snap_q;
   assign in_range = (delta >= CNT_W'(lo_bound)) && (delta <= CNT_W'(hi_bound));

   always_ff @(posedge ref_clk or negedge rst_ref_n) begin
      if (!rst_ref_n) begin
         win_q        <= '0;
         snap_q       <= '0;
         armed_q      <= 1'b0;
         verdict_vld  <= 1'b0;
         verdict_pass <= 1'b0;
         osc_stopped  <= 1'b0;
      end else begin
         verdict_vld <= 1'b0;
         if (win_last) begin
            win_q   <= '0;
            snap_q  <= bin_now;
            armed_q <= 1'b1;
            if (armed_q) begin
               verdict_vld  <= 1'b1;
               verdict_pass <= in_range;
               osc_stopped  <= (delta == '0);
            end
         end else begin
            win_q <= win_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/clksup_src_regs.sv
module clksup_src_regs
   import clksup_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic            ref_clk,
   input  logic            rst_ref_n,
   input  logic [NSRC-1:0] off_clr,
   input  logic [NSRC-1:0] off_set,
   input  logic [NPLL-1:0] pll_lock,
   input  logic            osc_ok,
   output logic [NSRC-1:0] src_off,
   output logic [NSRC-1:0] src_valid
);
   localparam logic [NSRC-1:0] WR_MASK = NSRC'((1 << SRC_PLL1) | (1 << SRC_PLL2));
   localparam int PLL_IDX [NPLL] = '{SRC_PLL1, SRC_PLL2};

   logic [NSRC-1:0] off_q;
   logic [NPLL-1:0] lock_s;

   always_ff @(posedge ref_clk or negedge rst_ref_n) begin
      if (!rst_ref_n) off_q <= WR_MASK;
      else            off_q <= ((off_q & ~off_clr) | off_set) & WR_MASK;
   end

   for (genvar p = 0; p < NPLL; p++) begin : g_lock
      logic [SYNC_STAGES-1:0] sh_q;
      always_ff @(posedge ref_clk or negedge rst_ref_n) begin
         if (!rst_ref_n) sh_q <= '0;
         else            sh_q <= {sh_q[SYNC_STAGES-2:0], pll_lock[p]};
      end
      assign lock_s[p] = sh_q[SYNC_STAGES-1];
   end

   always_comb begin
      src_valid          = '0;
      src_valid[SRC_OSC] = osc_ok;
      src_valid[SRC_REF] = rst_ref_n;
      for (int p = 0; p < NPLL; p++)
         src_valid[PLL_IDX[p]] = lock_s[p] & ~off_q[PLL_IDX[p]];
   end

   assign src_off = off_q;
endmodule

// File: rtl/clksup_glitchless_mux.sv
module clksup_glitchless_mux #(
   parameter int SYNC_STAGES = 2
) (
   input  logic osc_clk,
   input  logic ref_clk,
   input  logic por_n,
   input  logic kill_osc,
   input  logic want_osc,
   output logic en_osc,
   output logic en_ref,
   output logic sys_clk
);
   logic [SYNC_STAGES-1:0] oc_q, rc_q;
   logic                   clr_osc_n;

   assign clr_osc_n = por_n & ~kill_osc;

   // oscillator branch, advanced on oscillator falling edges
   always_ff @(negedge osc_clk or negedge clr_osc_n) begin
      if (!clr_osc_n) oc_q <= '0;
      else            oc_q <= {oc_q[SYNC_STAGES-2:0], want_osc & ~en_ref};
   end

   // reference branch, advanced on reference falling edges
   always_ff @(negedge ref_clk or negedge por_n) begin
      if (!por_n) rc_q <= '1;
      else        rc_q <= {rc_q[SYNC_STAGES-2:0], ~want_osc & ~en_osc};
   end

   assign en_osc  = oc_q[SYNC_STAGES-1];
   assign en_ref  = rc_q[SYNC_STAGES-1];
   assign sys_clk = (osc_clk & en_osc) | (ref_clk & en_ref);
endmodule

// File: rtl/clk_src_supervisor.sv
module clk_src_supervisor
   import clksup_pkg::*;
#(
   parameter int WIN_LEN     = 64,
   parameter int MAX_RATIO   = 8,
   parameter int BOUND_W     = 8,
   parameter int SYNC_STAGES = 2,
   localparam int TRIM_W     = 2 * BOUND_W
) (
   input  logic              por_n,
   input  logic              osc_clk,
   input  logic              ref_clk,
   input  logic [TRIM_W-1:0] trim_word,
   input  logic [NPLL-1:0]   pll_lock,
   input  logic [NSRC-1:0]   off_clr,
   input  logic [NSRC-1:0]   off_set,
   output logic [NSRC-1:0]   src_off,
   output logic [NSRC-1:0]   src_valid,
   output logic              use_osc,
   output logic              sys_clk
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("at least two synchroniser stages required");
   end

   logic [SYNC_STAGES-1:0] rs_q;
   logic                   rst_ref_n;

   always_ff @(posedge ref_clk or negedge por_n) begin
      if (!por_n) rs_q <= '0;
      else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
   end
   assign rst_ref_n = rs_q[SYNC_STAGES-1];

   logic v_vld, v_pass, osc_dead;

   clksup_freq_meter #(
      .WIN_LEN(WIN_LEN), .MAX_RATIO(MAX_RATIO),
      .BOUND_W(BOUND_W), .SYNC_STAGES(SYNC_STAGES)
   ) i_meter (
      .osc_clk     (osc_clk),
      .por_n       (por_n),
      .ref_clk     (ref_clk),
      .rst_ref_n   (rst_ref_n),
      .lo_bound    (trim_word[BOUND_W-1:0]),
      .hi_bound    (trim_word[TRIM_W-1:BOUND_W]),
      .verdict_vld (v_vld),
      .verdict_pass(v_pass),
      .osc_stopped (osc_dead)
   );

   clksup_src_regs #(.SYNC_STAGES(SYNC_STAGES)) i_regs (
      .ref_clk  (ref_clk),
      .rst_ref_n(rst_ref_n),
      .off_clr  (off_clr),
      .off_set  (off_set),
      .pll_lock (pll_lock),
      .osc_ok   (v_pass),
      .src_off  (src_off),
      .src_valid(src_valid)
   );

   sel_state_e st_q;
   logic       fallback;

   always_ff @(posedge ref_clk or negedge rst_ref_n) begin
      if (!rst_ref_n) begin
         st_q <= SEL_BOOT;
      end else begin
         case (st_q)
            SEL_BOOT: if (v_vld) st_q <= v_pass ? SEL_OSC : SEL_FALL;
            SEL_OSC:  if (v_vld && !v_pass) st_q <= SEL_FALL;
            default:  st_q <= SEL_FALL;
         endcase
      end
   end

   assign use_osc  = (st_q == SEL_OSC);
   assign fallback = (st_q == SEL_FALL);

   logic en_osc, en_ref;

   clksup_glitchless_mux #(.SYNC_STAGES(SYNC_STAGES)) i_mux (
      .osc_clk (osc_clk),
      .ref_clk (ref_clk),
      .por_n   (por_n),
      .kill_osc(osc_dead),
      .want_osc(use_osc),
      .en_osc  (en_osc),
      .en_ref  (en_ref),
      .sys_clk (sys_clk)
   );
endmodule

// File: rtl/clksup_chk.sv
module clksup_chk (
   input logic       ref_clk,
   input logic       rst_ref_n,
   input logic       use_osc,
   input logic       fallback,
   input logic [7:0] src_valid,
   input logic [7:0] src_off,
   input logic [7:0] off_clr,
   input logic [7:0] off_set,
   input logic       en_osc,
   input logic       en_ref
);
   // R10
   excl_en_chk: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
      !(en_osc && en_ref));

   // R6
   sticky_fall_chk: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
      fallback |=> (fallback && !use_osc));

   // R4
   osc_pass_chk: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
      $rose(use_osc) |-> src_valid[0]);

   // R8
   clr_bit1_chk: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
      (off_clr[1] && !off_set[1]) |=> !src_off[1]);

   // R8
   set_bit6_chk: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
      off_set[6] |=> src_off[6]);

   // R9
   pll1_gate_chk: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
      src_off[1] |-> !src_valid[1]);

   // R9
   pll2_gate_chk: assert property (@(posedge ref_clk) disable iff (!rst_ref_n)
      src_off[6] |-> !src_valid[6]);
endmodule

bind clk_src_supervisor clksup_chk i_chk (.*);

// File: tb/test_clk_src_supervisor.sv
`timescale 1ns/1ps
module test_clk_src_supervisor;
   logic        por_n = 1'b0;
   logic        osc_clk = 1'b0;
   logic        ref_clk = 1'b0;
   logic [15:0] trim_word = 16'h3C28;
   logic [1:0]  pll_lock = '0;
   logic [7:0]  off_clr = '0;
   logic [7:0]  off_set = '0;
   logic [7:0]  src_off, src_valid;
   logic        use_osc, sys_clk;

   int  checks = 0;
   int  errors = 0;
   bit  done = 0;
   real osc_half = 5.0;
   int  sys_edges = 0;

   clk_src_supervisor i_clk_src_supervisor (
      .por_n(por_n), .osc_clk(osc_clk), .ref_clk(ref_clk),
      .trim_word(trim_word), .pll_lock(pll_lock),
      .off_clr(off_clr), .off_set(off_set),
      .src_off(src_off), .src_valid(src_valid),
      .use_osc(use_osc), .sys_clk(sys_clk)
   );

   always #4 ref_clk = ~ref_clk;

   always begin
      if (osc_half == 0.0) begin
         osc_clk = 1'b0;
         #1;
      end else begin
         #(osc_half) osc_clk = ~osc_clk;
      end
   end

   always @(posedge sys_clk) sys_edges++;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_rng(input string req, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge ref_clk);
   endtask

   task automatic sys_rate(input string req, input int lo, input int hi);
      int e0;
      e0 = sys_edges;
      cyc(100);
      check_rng(req, sys_edges - e0, lo, hi);
   endtask

   task automatic wr(input logic [7:0] clr, input logic [7:0] set);
      off_clr = clr;
      off_set = set;
      @(negedge ref_clk);
      off_clr = '0;
      off_set = '0;
   endtask

   // cycle model of disable register, lock synchronisers and reset release
   logic [7:0] m_off = 8'h42;
   logic [1:0] m_l0 = '0, m_l1 = '0;
   logic [1:0] m_rs = '0;

   always @(posedge ref_clk) begin
      logic [7:0] exp_v;
      if (!por_n) begin
         m_off = 8'h42; m_l0 = '0; m_l1 = '0; m_rs = '0;
      end else begin
         if (m_rs[1]) begin
            m_off = ((m_off & ~off_clr) | off_set) & 8'h42;
            m_l1  = m_l0;
            m_l0  = pll_lock;
         end
         m_rs = {m_rs[0], 1'b1};
      end
      #2;
      exp_v = '0;
      exp_v[4] = m_rs[1];
      exp_v[1] = m_l1[0] & ~m_off[1];
      exp_v[6] = m_l1[1] & ~m_off[6];
      check("R8 per-cycle src_off", src_off, m_off);
      check("R9 per-cycle src_valid", src_valid & 8'hFE, exp_v);
   end

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      cyc(10);
      // R1 reset state
      check("R1 use_osc", use_osc, 0);
      check("R1 src_off", src_off, 8'h42);
      check("R1 src_valid", src_valid, 8'h00);
      sys_rate("R1 sys_clk rate", 98, 102);
      por_n = 1'b1;
      cyc(40);
      check("R2 early use_osc", use_osc, 0);
      cyc(60);
      check("R2 first window discarded", use_osc, 0);
      cyc(120);
      check("R4 oscillator selected", use_osc, 1);
      check("R3 verdict pass", src_valid[0], 1);
      cyc(10);
      sys_rate("R4 sys_clk at osc rate", 78, 82);

      // R8 R9 register and lock behaviour
      wr(8'h02, 8'h00);
      check("R8 clear bit1", src_off, 8'h40);
      pll_lock = 2'b01;
      cyc(3);
      check("R9 pll1 valid", src_valid[1], 1);
      wr(8'h02, 8'h02);
      check("R8 set wins over clear", src_off, 8'h42);
      check("R9 pll1 gated by disable", src_valid[1], 0);
      wr(8'hFF, 8'h00);
      check("R8 clear all", src_off, 8'h00);
      pll_lock = 2'b11;
      cyc(3);
      check("R9 both pll valid", src_valid & 8'h42, 8'h42);
      wr(8'h00, 8'h81);
      check("R8 unstorable bits ignored", src_off, 8'h00);
      wr(8'h00, 8'h40);
      check("R9 pll2 gated", src_valid[6], 0);
      pll_lock = 2'b00;
      cyc(3);
      check("R9 pll1 lock lost", src_valid[1], 0);

      // R6 later failure (oscillator too fast)
      osc_half = 2.5;
      cyc(200);
      check("R6 valid cleared", src_valid[0], 0);
      check("R6 fallback", use_osc, 0);
      cyc(10);
      sys_rate("R6 sys_clk at ref rate", 98, 102);
      osc_half = 5.0;
      cyc(200);
      check("R3 valid follows last verdict", src_valid[0], 1);
      check("R6 fallback sticky", use_osc, 0);

      // R5 first verdict fails under a narrowed window
      por_n = 1'b0;
      trim_word = 16'h3C37;
      cyc(5);
      por_n = 1'b1;
      cyc(260);
      check("R3 narrowed window rejects", src_valid[0], 0);
      check("R5 reference kept", use_osc, 0);
      trim_word = 16'h3C28;
      cyc(200);
      check("R3 widened window accepts", src_valid[0], 1);
      check("R5 no late switch", use_osc, 0);

      // R7 oscillator stops while selected
      por_n = 1'b0;
      cyc(5);
      por_n = 1'b1;
      cyc(220);
      check("R4 oscillator selected again", use_osc, 1);
      osc_half = 0.0;
      cyc(200);
      check("R7 fallback on dead osc", use_osc, 0);
      check("R7 valid cleared", src_valid[0], 0);
      cyc(10);
      sys_rate("R7 sys_clk recovers to ref", 98, 102);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule